// File: doc/BRIEF.md
# Complementary Half-Bridge PWM with Dead Band

This block drives the upper and lower switches of one half-bridge leg from a single pulse-width setting. A free-running cycle counter is compared against a duty value to form an internal raw PWM level. The upper gate follows that level, and the lower gate follows its inverse. Each gate may switch on only after its partner has been off for a programmable number of clock cycles. Turn-off is never delayed, so the two switches cannot conduct at the same time.

The period, duty and dead-band settings come in on plain input ports. They are captured only at the start of each PWM cycle, so a change on those ports never produces a shortened or stretched cycle. Pulses or gaps shorter than the dead band are swallowed, and both gates stay low for that interval. Both gates are registered, so they show the raw level of the previous clock cycle.

Top module: `cpwm_leg`

## Requirements
- R1: The cycle counter starts at 0 and steps by one per clock up to P-1, where P is the captured period, then returns to 0. A period of 0 or 1 makes every cycle a restart.
- R2: The raw level is 1 when the counter is below the captured duty D and 0 otherwise. D=0 keeps it at 0. D>=P keeps it at 1.
- R3: The outputs are registered. The gate values in cycle n+1 follow from the raw level and the gate history up to cycle n.
- R4: gate_hi_o and gate_lo_o are never 1 in the same cycle.
- R5: With a captured dead band T>0, a gate goes to 1 in cycle n+1 only if its partner was 0 in each of cycles n-T+1..n. The first cycle after reset counts as a partner-low cycle.
- R6: A gate falls in the cycle right after the raw level stops requesting it (raw 0 for the upper gate, raw 1 for the lower gate).
- R7: If a raw pulse or gap lasts fewer cycles than T, the gate it would enable stays 0 throughout, and both gates are then 0.
- R8: With T=0, gate_hi_o equals the previous cycle's raw level and gate_lo_o equals its inverse.
- R9: Period, duty and dead band are captured from the inputs only at a counter restart (and while reset is held). Between restarts, changes on the inputs have no effect on the outputs.
- R10: While rst_i is high, and in the first cycle after it falls, both gates are 0. The counter resumes at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| period_i | input | CNT_W | Cycle length in clocks |
| duty_i | input | CNT_W | Upper-gate on time in clocks |
| dead_i | input | DT_W | Dead band in clocks |
| gate_hi_o | output | 1 | Upper switch gate |
| gate_lo_o | output | 1 | Lower switch gate |

## Verification
The bench builds the leg with an 8-bit counter and a 4-bit dead-band field. Short periods therefore wrap many times in a brief run, and the largest dead band (15) can exceed a whole period, which drives the partner-low run counters into saturation. These widths also bring within reach periods of 0 and 1, duty values at and above the period, and dead bands longer than a pulse or a gap. A reference model built from the requirements predicts both gates for every cycle, including mid-cycle setting changes and a reset in the middle of a run.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Default widths for the cycle counter and the dead-band field
    localparam int DEF_CNT_W = 16;
    localparam int DEF_DT_W  = 8;

    // Gate index for the two sides of the leg
    typedef enum logic {
        SIDE_HI = 1'b0,
        SIDE_LO = 1'b1
    } side_e;

    // Registered gate pair
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    // Side index as an integer for array selection
    function automatic int side_idx(side_e s);
        return (s == SIDE_HI) ? 0 : 1;
    endfunction

    // Partner index of a side
    function automatic int partner_idx(int s);
        return (s == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/cpwm_cfg_hold.sv
module cpwm_cfg_hold #(
    parameter int CNT_W = cpwm_pkg::DEF_CNT_W,
    parameter int DT_W  = cpwm_pkg::DEF_DT_W
) (
    input  logic             clk_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] duty_q,
    output logic [DT_W-1:0]  dead_q
);

    // Settings change only on a load; the caller asserts load at a
    // counter restart and throughout reset.
    always_ff @(posedge clk_i) begin
        if (load_i) begin
            period_q <= period_i;
            duty_q   <= duty_i;
            dead_q   <= dead_i;
        end
    end

endmodule

// File: rtl/cpwm_cycle_ctr.sv
module cpwm_cycle_ctr #(
    parameter int CNT_W = cpwm_pkg::DEF_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             wrap_o,
    output logic             raw_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // A zero period behaves like a period of one
    always_comb begin
        wrap_o = (period_i == '0) || (cnt_q >= (period_i - CNT_ONE));
        raw_o  = (cnt_q < duty_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/cpwm_dead_gate.sv
module cpwm_dead_gate #(
    parameter int DT_W = cpwm_pkg::DEF_DT_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            want_i,
    input  logic            partner_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            gate_o
);

    localparam logic [DT_W-1:0] RUN_MAX = '1;
    localparam logic [DT_W-1:0] RUN_ONE = {{(DT_W-1){1'b0}}, 1'b1};
    localparam logic [DT_W:0]   EXT_ONE = {{DT_W{1'b0}}, 1'b1};

    // Count of earlier consecutive cycles with the partner gate low
    logic [DT_W-1:0] run_q;
    // Same count including the current cycle
    logic [DT_W:0]   run_incl;
    logic            clear_ok;
    logic            gate_d;

    always_comb begin
        run_incl = partner_i ? '0 : ({1'b0, run_q} + EXT_ONE);
        clear_ok = (dead_i == '0) || (run_incl >= {1'b0, dead_i});
        gate_d   = want_i && clear_ok;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q  <= '0;
            gate_o <= 1'b0;
        end else begin
            gate_o <= gate_d;
            if (partner_i) begin
                run_q <= '0;
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + RUN_ONE;
            end
        end
    end

endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg #(
    parameter int CNT_W = cpwm_pkg::DEF_CNT_W,
    parameter int DT_W  = cpwm_pkg::DEF_DT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o
);

    import cpwm_pkg::*;

    localparam int N_SIDES = 2;

    logic [CNT_W-1:0]   per_a;
    logic [CNT_W-1:0]   duty_a;
    logic [DT_W-1:0]    dead_a;
    logic               wrap;
    logic               raw;
    logic               cfg_load;
    logic [N_SIDES-1:0] want;
    logic [N_SIDES-1:0] gate;
    leg_t               leg;

    assign cfg_load = rst_i || wrap;

    cpwm_cfg_hold #(
        .CNT_W (CNT_W),
        .DT_W  (DT_W)
    ) cfg_i (
        .clk_i    (clk_i),
        .load_i   (cfg_load),
        .period_i (period_i),
        .duty_i   (duty_i),
        .dead_i   (dead_i),
        .period_q (per_a),
        .duty_q   (duty_a),
        .dead_q   (dead_a)
    );

    cpwm_cycle_ctr #(
        .CNT_W (CNT_W)
    ) ctr_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .period_i (per_a),
        .duty_i   (duty_a),
        .wrap_o   (wrap),
        .raw_o    (raw)
    );

    assign want[side_idx(SIDE_HI)] = raw;
    assign want[side_idx(SIDE_LO)] = ~raw;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        cpwm_dead_gate #(
            .DT_W (DT_W)
        ) gate_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .want_i    (want[s]),
            .partner_i (gate[partner_idx(s)]),
            .dead_i    (dead_a),
            .gate_o    (gate[s])
        );
    end

    assign leg.hi    = gate[side_idx(SIDE_HI)];
    assign leg.lo    = gate[side_idx(SIDE_LO)];
    assign gate_hi_o = leg.hi;
    assign gate_lo_o = leg.lo;

endmodule

// File: rtl/cpwm_leg_chk.sv
module cpwm_leg_chk #(
    parameter int CNT_W = cpwm_pkg::DEF_CNT_W,
    parameter int DT_W  = cpwm_pkg::DEF_DT_W
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             hi_i,
    input logic             lo_i,
    input logic             raw_i,
    input logic             wrap_i,
    input logic [CNT_W-1:0] per_i,
    input logic [CNT_W-1:0] duty_i,
    input logic [DT_W-1:0]  dead_i
);

    localparam logic [31:0] RUN_SAT = 32'hFFFF_FFFF;

    // Cycles each gate has been low, not counting the current one
    logic [31:0] hi_run_q;
    logic [31:0] lo_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= hi_i ? '0 : ((hi_run_q == RUN_SAT) ? hi_run_q : hi_run_q + 32'd1);
            lo_run_q <= lo_i ? '0 : ((lo_run_q == RUN_SAT) ? lo_run_q : lo_run_q + 32'd1);
        end
    end

    // R4
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hi_i && lo_i));

    // R5
    hi_dead_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hi_i) |-> (lo_run_q >= 32'($past(dead_i))));

    // R5
    lo_dead_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lo_i) |-> (hi_run_q >= 32'($past(dead_i))));

    // R6
    hi_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !raw_i |=> !hi_i);

    // R6
    lo_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        raw_i |=> !lo_i);

    // R8
    zero_dead_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dead_i == '0) |=> ((hi_i == $past(raw_i)) && (lo_i == !$past(raw_i))));

    // R9
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> ($stable(per_i) && $stable(duty_i) && $stable(dead_i)));

    // R10
    reset_low_chk: assert property (@(posedge clk_i)
        rst_i |=> (!hi_i && !lo_i));

endmodule

bind cpwm_leg cpwm_leg_chk #(
    .CNT_W (CNT_W),
    .DT_W  (DT_W)
) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hi_i   (gate_hi_o),
    .lo_i   (gate_lo_o),
    .raw_i  (raw),
    .wrap_i (wrap),
    .per_i  (per_a),
    .duty_i (duty_a),
    .dead_i (dead_a)
);

// File: tb/cpwm_leg_tb_top.sv
`timescale 1ns/1ps
module cpwm_leg_tb_top;

    localparam int CNT_W    = 8;
    localparam int DT_W     = 4;
    localparam int WDOG_CYC = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] period_in = '0;
    logic [CNT_W-1:0] duty_in = '0;
    logic [DT_W-1:0]  dead_in = '0;
    logic             gate_hi;
    logic             gate_lo;

    always #2.5 clk = ~clk;

    cpwm_leg #(
        .CNT_W (CNT_W),
        .DT_W  (DT_W)
    ) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .period_i  (period_in),
        .duty_i    (duty_in),
        .dead_i    (dead_in),
        .gate_hi_o (gate_hi),
        .gate_lo_o (gate_lo)
    );

    typedef struct {
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string tag = "R10";

    // Reference model state, built from the requirements
    int m_cnt, m_per, m_duty, m_dead;
    int m_hi_low, m_lo_low;

    // Monitor: pops one expected pair per cycle, checks overlap every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (gate_hi && gate_lo) begin
                n_errors++;
                $display("FAIL R4: hi/lo actual %b/%b expected not both 1", gate_hi, gate_lo);
            end
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (gate_hi !== e.hi || gate_lo !== e.lo) begin
                    n_errors++;
                    $display("FAIL %s: hi/lo actual %b/%b expected %b/%b at %0t",
                             e.tag, gate_hi, gate_lo, e.hi, e.lo, $time);
                end
            end
        end
    end

    task automatic set_cfg(int p, int d, int t);
        period_in = CNT_W'(p);
        duty_in   = CNT_W'(d);
        dead_in   = DT_W'(t);
    endtask

    // Model one cycle: predict the next output pair, advance the counter
    task automatic step();
        logic r, eh, el;
        exp_t e;
        r  = (m_cnt < m_duty);
        eh = r && (m_dead == 0 || m_lo_low >= m_dead);
        el = !r && (m_dead == 0 || m_hi_low >= m_dead);
        e.hi = eh;
        e.lo = el;
        e.tag = tag;
        exp_q.push_back(e);
        m_hi_low = eh ? 0 : m_hi_low + 1;
        m_lo_low = el ? 0 : m_lo_low + 1;
        if (m_per <= 1 || m_cnt >= m_per - 1) begin
            m_cnt  = 0;
            m_per  = int'(period_in);
            m_duty = int'(duty_in);
            m_dead = int'(dead_in);
        end else begin
            m_cnt++;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // R10: hold reset, check both gates low, restart the model
    task automatic do_reset(int cycles);
        exp_t e;
        rst = 1'b1;
        exp_q.delete();
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            n_checks++;
            if (gate_hi !== 1'b0 || gate_lo !== 1'b0) begin
                n_errors++;
                $display("FAIL R10: hi/lo actual %b/%b expected 0/0 in reset", gate_hi, gate_lo);
            end
        end
        rst = 1'b0;
        m_cnt    = 0;
        m_per    = int'(period_in);
        m_duty   = int'(duty_in);
        m_dead   = int'(dead_in);
        m_hi_low = 1;
        m_lo_low = 1;
        e.hi = 1'b0;
        e.lo = 1'b0;
        e.tag = "R10";
        exp_q.push_back(e);
    endtask

    initial begin
        #1;
        set_cfg(10, 4, 2);
        do_reset(4);
        tag = "R1 R3 R5 R6";
        run(40);
        // R8 and R9: new settings take hold only at the next restart
        tag = "R8 R9";
        set_cfg(10, 7, 0);
        run(30);
        // R2: duty at zero, equal to period, above period
        tag = "R2";
        set_cfg(8, 0, 3);
        run(24);
        set_cfg(8, 8, 3);
        run(24);
        set_cfg(8, 11, 3);
        run(24);
        // R7: pulse shorter than dead band, then gap shorter than dead band
        tag = "R7";
        set_cfg(12, 2, 4);
        run(36);
        set_cfg(12, 10, 4);
        run(36);
        // R7: dead band longer than both pulse and gap, saturating runs
        set_cfg(6, 3, 15);
        run(30);
        // R9: mid-cycle change must wait for the restart
        tag = "R9";
        set_cfg(16, 8, 1);
        run(20);
        set_cfg(9, 2, 1);
        run(5);
        set_cfg(9, 6, 2);
        run(40);
        // R1: period of one and of zero restart every cycle
        tag = "R1";
        set_cfg(1, 1, 0);
        run(20);
        set_cfg(0, 1, 0);
        run(20);
        set_cfg(5, 2, 0);
        run(20);
        // R10: reset in the middle of a run
        set_cfg(7, 3, 1);
        do_reset(3);
        tag = "R10 R5";
        run(30);
        done = 1'b1;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual run not finished expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule